// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block pairs two eight-line interrupt controllers, a primary and a secondary, and turns an acknowledge strobe from the CPU into one 8-bit vector. Each controller keeps a request register, an in-service register and a rotating priority base. A request pending on the secondary is forwarded as an edge-style request onto the primary's cascade line (line 2). The primary's interrupt output is raised whenever it has a request that outranks everything in service.

On an acknowledge the block decides which controller supplies the vector. A grant on the primary's cascade line hands the acknowledge to the secondary. The block then updates the in-service and request registers of each controller taking part. Auto end-of-interrupt, with optional rotation of the priority base, is applied per controller. The vector and a one-cycle valid pulse are registered on the cycle after the strobe. All configuration arrives on ports: vector bases, trigger modes, and the auto end-of-interrupt and rotation enables.

Top module: `cascade_ack_seq`

## Requirements
- R1: After a synchronous active-low reset, `int_out`, `vec_valid` and `vec` are 0, no request or in-service bit is set, and both priority bases are 0.
- R2: An edge-triggered line (its trigger bit 0) latches a request on a 0-to-1 change of the input. Acknowledging that line clears the request, and a line that stays high does not request again.
- R3: A level-triggered line (its trigger bit 1) requests exactly while its input is high. Acknowledge leaves the request in place, so a held line is granted again on the next acknowledge.
- R4: The highest priority goes to the line equal to the priority base, and priority falls with increasing line number modulo 8. With base 0, line 0 beats all others.
- R5: With auto end-of-interrupt off, an acknowledge sets the in-service bit of the granted line. A request is only raised to `int_out` when it outranks every in-service line of that controller.
- R6: With auto end-of-interrupt on, no in-service bit is set. If rotation is also on, the priority base becomes (granted line + 1) mod 8.
- R7: A pending secondary request raises the primary's line 2. When the primary grants line 2, the secondary is acknowledged and `vec` = secondary base + secondary line.
- R8: If the primary grants line 2 while the secondary has no grantable request, `vec` = secondary base + 7, and the secondary's state is untouched.
- R9: If the primary has no grant at acknowledge, `vec` = primary base + 7 and no controller state changes.
- R10: Only bits 7:3 of each vector base are used. The low three bits of `vec` are always the line number.
- R11: `vec_valid` is high for exactly the one cycle after each cycle with `ack` high, and `vec` holds its value until the next acknowledge. `int_out` reflects the state as updated by the acknowledge.
- R12: A request edge in the same cycle as `ack` does not affect that acknowledge's vector, but it is captured and served later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 16 | Request inputs; bits 7:0 primary, bits 15:8 secondary |
| m_base | input | 8 | Primary vector base (bits 7:3 used) |
| s_base | input | 8 | Secondary vector base (bits 7:3 used) |
| m_trig | input | 8 | Primary trigger modes, 1 = level |
| s_trig | input | 8 | Secondary trigger modes, 1 = level |
| m_aeoi | input | 1 | Primary auto end-of-interrupt enable |
| s_aeoi | input | 1 | Secondary auto end-of-interrupt enable |
| m_rot | input | 1 | Primary rotate-on-auto-EOI enable |
| s_rot | input | 1 | Secondary rotate-on-auto-EOI enable |
| ack | input | 1 | Acknowledge strobe, one cycle per acknowledge |
| int_out | output | 1 | Interrupt request to the CPU |
| vec | output | 8 | Registered interrupt vector |
| vec_valid | output | 1 | One-cycle pulse marking a new vector |

## Verification
The assertions assume that `ack` is a single-cycle strobe and that the vector bases do not move between the strobe and the following cycle. They also assume no end-of-interrupt path exists, so in-service bits can only grow between resets. The stimulus changes configuration only while reset is held and raises `ack` for one cycle at a time. It keeps the external line 2 of the primary low so that cascade behaviour is observed on its own.

// File: rtl/cas_pkg.sv
// Package: shared sizes and helpers for the cascaded acknowledge sequencer.
// Assumes eight request lines per controller and an 8-bit vector.
package cas_pkg;
    localparam int NLINE = 8;
    localparam int LW    = $clog2(NLINE);
    localparam int VW    = 8;
    localparam int BASEW = VW - LW;
    localparam logic [LW-1:0] CASC_LINE = LW'(2);
    localparam logic [LW-1:0] SPUR_LINE = LW'(NLINE - 1);

    typedef logic [NLINE-1:0] line_vec_t;
    typedef logic [LW-1:0]    line_idx_t;

    // One-hot decode of a line index.
    function automatic line_vec_t line_bit(input line_idx_t idx);
        line_vec_t r;
        r = '0;
        r[idx] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/cas_prio_pick.sv
// Module: rotating priority resolver for one controller.
// Finds the best pending line relative to the priority base and reports a
// grant only if it outranks every in-service line. Purely combinational.
module cas_prio_pick
    import cas_pkg::*;
(
    input  line_vec_t req,
    input  line_vec_t svc,
    input  line_idx_t base,
    output logic      hit,
    output line_idx_t line
);
    logic [LW:0] req_rank;
    logic [LW:0] svc_rank;

    // Rank of the best pending and best in-service line (NLINE = none).
    always_comb begin
        req_rank = (LW+1)'(NLINE);
        svc_rank = (LW+1)'(NLINE);
        for (int i = NLINE - 1; i >= 0; i--) begin
            if (req[LW'(i) + base]) req_rank = (LW+1)'(i);
            if (svc[LW'(i) + base]) svc_rank = (LW+1)'(i);
        end
    end

    // Grant decision and conversion from rank back to line number.
    always_comb begin
        hit  = req_rank < svc_rank;
        line = req_rank[LW-1:0] + base;
    end
endmodule

// File: rtl/cas_pic_core.sv
// Module: state of one eight-line controller.
// Holds edge history, request, in-service and priority base registers and
// applies acknowledge updates. Assumes ack_take is only asserted when the
// resolver reports a grant and ack_line equals that granted line.
module cas_pic_core
    import cas_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  line_vec_t lvl,
    input  line_vec_t trig,
    input  line_vec_t set_pulse,
    input  logic      ack_take,
    input  line_idx_t ack_line,
    input  logic      aeoi,
    input  logic      rot,
    output logic      grant,
    output line_idx_t grant_line,
    output line_vec_t isr_o
);
    line_vec_t last_q, irr_q, isr_q;
    line_idx_t base_q;
    line_vec_t rise, clr, irr_d, isr_d;
    line_idx_t base_d;

    // Next-state logic for requests, in-service bits and priority base.
    always_comb begin
        rise  = lvl & ~last_q;
        clr   = ack_take ? line_bit(ack_line) : '0;
        irr_d = (trig & (lvl | set_pulse))
              | (~trig & ((irr_q & ~clr) | rise | set_pulse));
        isr_d = isr_q;
        if (ack_take && !aeoi) isr_d = isr_q | line_bit(ack_line);
        base_d = base_q;
        if (ack_take && aeoi && rot) base_d = ack_line + LW'(1);
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            irr_q  <= '0;
            isr_q  <= '0;
            base_q <= '0;
        end else begin
            last_q <= lvl;
            irr_q  <= irr_d;
            isr_q  <= isr_d;
            base_q <= base_d;
        end
    end

    cas_prio_pick u_pick (
        .req  (irr_q),
        .svc  (isr_q),
        .base (base_q),
        .hit  (grant),
        .line (grant_line)
    );

    assign isr_o = isr_q;
endmodule

// File: rtl/cascade_ack_seq.sv
// Module: top of the cascaded acknowledge sequencer.
// Forwards secondary requests to primary line 2, picks the vector source on
// an acknowledge and registers the vector. Assumes ack is a one-cycle strobe.
module cascade_ack_seq
    import cas_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2*NLINE-1:0] irq_lines,
    input  logic [VW-1:0]    m_base,
    input  logic [VW-1:0]    s_base,
    input  logic [NLINE-1:0] m_trig,
    input  logic [NLINE-1:0] s_trig,
    input  logic             m_aeoi,
    input  logic             s_aeoi,
    input  logic             m_rot,
    input  logic             s_rot,
    input  logic             ack,
    output logic             int_out,
    output logic [VW-1:0]    vec,
    output logic             vec_valid
);
    logic      m_grant, s_grant;
    line_idx_t m_line, s_line;
    line_vec_t m_isr, s_isr;
    line_vec_t casc_pulse;
    logic      m_take, s_take;
    logic [VW-1:0] vec_d;
    logic [VW-1:0] vec_q;
    logic          valid_q;

    // Cascade forwarding and acknowledge routing to each controller.
    always_comb begin
        casc_pulse = (s_grant && !ack) ? line_bit(CASC_LINE) : '0;
        m_take     = ack && m_grant;
        s_take     = m_take && (m_line == CASC_LINE) && s_grant;
    end

    cas_pic_core u_mst (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (irq_lines[NLINE-1:0]),
        .trig       (m_trig),
        .set_pulse  (casc_pulse),
        .ack_take   (m_take),
        .ack_line   (m_line),
        .aeoi       (m_aeoi),
        .rot        (m_rot),
        .grant      (m_grant),
        .grant_line (m_line),
        .isr_o      (m_isr)
    );

    cas_pic_core u_slv (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (irq_lines[2*NLINE-1:NLINE]),
        .trig       (s_trig),
        .set_pulse  ('0),
        .ack_take   (s_take),
        .ack_line   (s_line),
        .aeoi       (s_aeoi),
        .rot        (s_rot),
        .grant      (s_grant),
        .grant_line (s_line),
        .isr_o      (s_isr)
    );

    // Vector selection: primary, secondary, or a spurious line 7.
    always_comb begin
        if (!m_grant)
            vec_d = {m_base[VW-1:LW], SPUR_LINE};
        else if (m_line == CASC_LINE)
            vec_d = {s_base[VW-1:LW], (s_grant ? s_line : SPUR_LINE)};
        else
            vec_d = {m_base[VW-1:LW], m_line};
    end

    // Output registers: vector held between acknowledges, one-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= ack;
            if (ack) vec_q <= vec_d;
        end
    end

    assign int_out   = m_grant;
    assign vec       = vec_q;
    assign vec_valid = valid_q;
endmodule

// File: rtl/cascade_ack_seq_chk.sv
// Checker: temporal properties of the acknowledge sequencer, bound to the top.
// Assumes ack is a one-cycle strobe and that no end-of-interrupt path exists.
module cascade_ack_seq_chk
    import cas_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          ack,
    input logic          int_out,
    input logic          vec_valid,
    input logic [VW-1:0] vec,
    input logic [VW-1:0] m_base,
    input logic [VW-1:0] s_base,
    input logic          m_aeoi,
    input logic          s_aeoi,
    input line_vec_t     m_isr,
    input line_vec_t     s_isr
);
    p_valid_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> vec_valid);

    p_valid_only_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !vec_valid);

    p_spurious_master_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_out) |=> (vec == {$past(m_base[VW-1:LW]), SPUR_LINE}));

    p_vec_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack) |=> (vec[VW-1:LW] == $past(m_base[VW-1:LW])
                || vec[VW-1:LW] == $past(s_base[VW-1:LW])));

    p_isr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && !m_aeoi) |=> ($countones(m_isr) == $countones($past(m_isr)) + 1));

    p_aeoi_no_isr_m_r6: assert property (@(posedge clk) disable iff (!rst_n)
        m_aeoi |=> ((m_isr & ~$past(m_isr)) == '0));

    p_aeoi_no_isr_s_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_aeoi |=> ((s_isr & ~$past(s_isr)) == '0));
endmodule

bind cascade_ack_seq cascade_ack_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .int_out   (int_out),
    .vec_valid (vec_valid),
    .vec       (vec),
    .m_base    (m_base),
    .s_base    (s_base),
    .m_aeoi    (m_aeoi),
    .s_aeoi    (s_aeoi),
    .m_isr     (m_isr),
    .s_isr     (s_isr)
);

// File: tb/cascade_ack_seq_bench.sv
// Bench: sweeps of single-line, cascade, nesting and rotation scenarios with
// vectors computed arithmetically from the requirements.
module cascade_ack_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lines = '0;
    logic [7:0]  m_base = 8'h27;
    logic [7:0]  s_base = 8'h75;
    logic [7:0]  m_trig = '0;
    logic [7:0]  s_trig = '0;
    logic        m_aeoi = 1'b0, s_aeoi = 1'b0, m_rot = 1'b0, s_rot = 1'b0;
    logic        ack = 1'b0;
    logic        int_out, vec_valid;
    logic [7:0]  vec;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cascade_ack_seq u_cascade_ack_seq (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .m_base(m_base), .s_base(s_base), .m_trig(m_trig), .s_trig(s_trig),
        .m_aeoi(m_aeoi), .s_aeoi(s_aeoi), .m_rot(m_rot), .s_rot(s_rot),
        .ack(ack), .int_out(int_out), .vec(vec), .vec_valid(vec_valid)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        ack = 1'b0;
        irq_lines = '0;
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
    endtask

    // One-cycle acknowledge; returns the vector seen after it and checks valid.
    task automatic do_ack(output logic [7:0] v);
        ack = 1'b1;
        cyc(1);
        ack = 1'b0;
        v = vec;
        chk(vec_valid === 1'b1, "R11 valid pulse", int'(vec_valid), 1);
    endtask

    function automatic int pick(input logic [7:0] pend, input int b);
        for (int k = 0; k < 8; k++)
            if (pend[(b + k) % 8]) return (b + k) % 8;
        return -1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] mb, sb;
        mb = m_base & 8'hF8;
        sb = s_base & 8'hF8;

        // R1: reset state
        do_reset();
        chk(int_out === 1'b0, "R1 int_out", int'(int_out), 0);
        chk(vec_valid === 1'b0, "R1 vec_valid", int'(vec_valid), 0);
        chk(vec === 8'h00, "R1 vec", int'(vec), 0);

        // R2, R4, R10: each primary line alone, edge mode, auto-EOI on
        m_aeoi = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (i == 2) continue;
            do_reset();
            irq_lines[i] = 1'b1;
            cyc(2);
            chk(int_out === 1'b1, "R2 edge latched", int'(int_out), 1);
            do_ack(v);
            chk(v === (mb + 8'(i)), "R10 primary vector", int'(v), int'(mb) + i);
            chk(int_out === 1'b0, "R2 held line no re-request", int'(int_out), 0);
            cyc(1);
            chk(vec_valid === 1'b0 && vec === (mb + 8'(i)), "R11 valid drops, vec held",
                int'(vec), int'(mb) + i);
        end

        // R7: each secondary line through the cascade
        s_aeoi = 1'b1;
        for (int j = 0; j < 8; j++) begin
            do_reset();
            irq_lines[8 + j] = 1'b1;
            cyc(3);
            chk(int_out === 1'b1, "R7 cascade raises int_out", int'(int_out), 1);
            do_ack(v);
            chk(v === (sb + 8'(j)), "R7 secondary vector", int'(v), int'(sb) + j);
            chk(int_out === 1'b0, "R7 cascade cleared", int'(int_out), 0);
        end

        // R4: two simultaneous lines, lower number first
        do_reset();
        irq_lines[6] = 1'b1;
        irq_lines[4] = 1'b1;
        cyc(2);
        do_ack(v);
        chk(v === mb + 8'd4, "R4 lower line first", int'(v), int'(mb) + 4);
        do_ack(v);
        chk(v === mb + 8'd6, "R4 then next", int'(v), int'(mb) + 6);

        // R3: level-triggered line stays pending across acknowledges
        m_trig = 8'h10;
        do_reset();
        irq_lines[4] = 1'b1;
        cyc(2);
        do_ack(v);
        chk(v === mb + 8'd4, "R3 level first", int'(v), int'(mb) + 4);
        chk(int_out === 1'b1, "R3 level not cleared", int'(int_out), 1);
        do_ack(v);
        chk(v === mb + 8'd4, "R3 level again", int'(v), int'(mb) + 4);
        irq_lines[4] = 1'b0;
        cyc(1);
        chk(int_out === 1'b0, "R3 follows input low", int'(int_out), 0);
        m_trig = 8'h00;

        // R5: in-service nesting with auto-EOI off
        m_aeoi = 1'b0;
        do_reset();
        irq_lines[3] = 1'b1;
        cyc(2);
        do_ack(v);
        chk(v === mb + 8'd3, "R5 first grant", int'(v), int'(mb) + 3);
        irq_lines[5] = 1'b1;
        cyc(2);
        chk(int_out === 1'b0, "R5 lower blocked by service", int'(int_out), 0);
        irq_lines[1] = 1'b1;
        cyc(2);
        chk(int_out === 1'b1, "R5 higher nests", int'(int_out), 1);
        do_ack(v);
        chk(v === mb + 8'd1, "R5 nested vector", int'(v), int'(mb) + 1);
        chk(int_out === 1'b0, "R5 still blocked", int'(int_out), 0);

        // R6: auto-EOI on, no rotation: no in-service block
        m_aeoi = 1'b1;
        do_reset();
        irq_lines[3] = 1'b1;
        cyc(2);
        do_ack(v);
        irq_lines[5] = 1'b1;
        cyc(2);
        chk(int_out === 1'b1, "R6 no in-service set", int'(int_out), 1);
        do_ack(v);
        chk(v === mb + 8'd5, "R6 lower served", int'(v), int'(mb) + 5);

        // R6: rotation sweep over every first-served primary line
        m_rot = 1'b1;
        for (int f = 0; f < 8; f++) begin
            logic [7:0] pend;
            int b;
            if (f == 2) continue;
            do_reset();
            irq_lines[f] = 1'b1;
            cyc(2);
            do_ack(v);
            chk(v === mb + 8'(f), "R6 rotation seed", int'(v), int'(mb) + f);
            irq_lines = '0;
            cyc(1);
            pend = 8'hFB;
            irq_lines[7:0] = pend;
            cyc(2);
            b = (f + 1) % 8;
            for (int k = 0; k < 7; k++) begin
                int e;
                e = pick(pend, b);
                do_ack(v);
                chk(v === mb + 8'(e), "R6 rotated order", int'(v), int'(mb) + e);
                pend[e] = 1'b0;
                b = (e + 1) % 8;
            end
            chk(int_out === 1'b0, "R6 all served", int'(int_out), 0);
        end
        m_rot = 1'b0;

        // R8: secondary withdraws its level request before acknowledge
        s_trig = 8'h08;
        do_reset();
        irq_lines[11] = 1'b1;
        cyc(3);
        irq_lines[11] = 1'b0;
        cyc(2);
        chk(int_out === 1'b1, "R8 cascade edge kept", int'(int_out), 1);
        do_ack(v);
        chk(v === sb + 8'd7, "R8 secondary spurious", int'(v), int'(sb) + 7);
        s_trig = 8'h00;

        // R9: acknowledge with nothing pending
        do_reset();
        do_ack(v);
        chk(v === mb + 8'd7, "R9 primary spurious", int'(v), int'(mb) + 7);
        chk(int_out === 1'b0, "R9 no state change", int'(int_out), 0);

        // R12: edge in the acknowledge cycle is captured for later
        do_reset();
        irq_lines[5] = 1'b1;
        cyc(2);
        irq_lines[1] = 1'b1;
        do_ack(v);
        chk(v === mb + 8'd5, "R12 same-cycle edge excluded", int'(v), int'(mb) + 5);
        chk(int_out === 1'b1, "R12 edge captured", int'(int_out), 1);
        do_ack(v);
        chk(v === mb + 8'd1, "R12 served later", int'(v), int'(mb) + 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule